// File: doc/BRIEF.md
# Single-Bit Configuration Upset Injector

This block emulates a single-event upset in FPGA configuration memory. Configuration records are four bytes long: a layer byte, a column byte, a row byte and a data byte. The layer byte picks the kind of resource and the column and row bytes pick its location. A host streams a target record into the block one byte at a time, in that order, using valid/ready handshaking. It then issues an inject command together with a bit index.

On an accepted inject command, the block emits a copy of the target record in which exactly one data bit is inverted. The layer, column and row bytes pass through unchanged. The block keeps its own copy of the original record. A later restore command re-emits that copy without change, which undoes the upset. Records leave the block byte-serially, in the same order they arrived, through a second valid/ready stream. A busy flag covers each emission, and an error pulse marks every command the block refuses.

The parameter `VALID_BITS` sets how many low data bits may be targeted. Its default is 6, so with the default a bit index of 6 or 7 is out of range.

Top module: `seu_bit_injector`

## Requirements
- R1: While reset is held and after it is released, `out_valid_o`, `busy_o` and `err_o` are 0 and `in_ready_o` is 1.
- R2: A record is captured from four accepted input bytes (`in_valid_i` and `in_ready_o` both high), taken in the order layer, column, row, data. `in_ready_o` is high only while the block is not busy and no injection is pending.
- R3: An accepted inject command makes `out_valid_o` rise on the next cycle. The block then emits layer, column and row unchanged, followed by data XOR (1 << `cmd_bit_i`), so exactly one data bit differs.
- R4: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_byte_o` stays stable. No byte is dropped or skipped.
- R5: `busy_o` is high from the cycle after a command is accepted until the cycle after the data byte's handshake. A command presented while `busy_o` is high, including in the cycle of the final handshake, is ignored: it produces no output and no error.
- R6: An inject whose bit index is `VALID_BITS` or above produces a one-cycle `err_o` pulse on the next cycle, emits nothing and leaves no injection pending.
- R7: After an injection, a restore command emits the original record unmodified. A restore with no injection pending produces an `err_o` pulse and emits nothing.
- R8: While an injection is pending, `in_ready_o` is low. A second inject command produces an `err_o` pulse and emits nothing.
- R9: An inject issued before any complete record has been captured produces an `err_o` pulse and emits nothing.
- R10: When inject and restore are asserted in the same idle cycle, the inject is handled and the restore is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Block can take an input byte |
| in_byte_i | input | BYTE_W | Input record byte (layer, column, row, data) |
| cmd_inject_i | input | 1 | Inject request, sampled for one cycle |
| cmd_restore_i | input | 1 | Restore request, sampled for one cycle |
| cmd_bit_i | input | IDX_W | Index of the data bit to invert |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Sink takes the output byte |
| out_byte_o | output | BYTE_W | Output record byte |
| busy_o | output | 1 | A record is being emitted |
| err_o | output | 1 | One-cycle pulse for a refused command |

## Verification
Two pairs of events can land in the same cycle.

The first is a command arriving in the cycle where the data byte completes its handshake. The bench raises inject in exactly the cycle `out_ready_i` takes the last byte of a restore record. At that point no injection is pending, so a design that does not block the command would start a new record. The bench then checks that `out_valid_o` stays low for several cycles and that `err_o` never pulses.

The second is inject and restore asserted together while the block is idle. The bench checks that the record that follows carries the flipped data bit and that no error pulse appears.

// File: rtl/seu_inj_pkg.sv
package seu_inj_pkg;
  localparam int unsigned REC_BYTES = 4;

  // emission / capture order, the sink decodes bytes by position
  typedef enum logic [1:0] {
    FLD_LAYER = 2'd0,
    FLD_COL   = 2'd1,
    FLD_ROW   = 2'd2,
    FLD_DATA  = 2'd3
  } fld_e;
endpackage

// File: rtl/rec_capture.sv
module rec_capture
  import seu_inj_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned REC_W = REC_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [REC_W-1:0]  rec_o,
  output logic              loaded_o
);
  localparam int unsigned HEAD_W = (REC_BYTES - 1) * BYTE_W;

  logic [1:0]        cnt_q;
  logic [HEAD_W-1:0] head_q;
  logic [REC_W-1:0]  rec_q;
  logic              loaded_q;
  logic              take;

  assign take = valid_i & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      head_q   <= '0;
      rec_q    <= '0;
      loaded_q <= 1'b0;
    end else if (take) begin
      if (cnt_q == FLD_DATA) begin
        // commit only when the record is whole
        rec_q    <= {head_q, byte_i};
        loaded_q <= 1'b1;
        cnt_q    <= '0;
      end else begin
        head_q <= {head_q[HEAD_W-BYTE_W-1:0], byte_i};
        cnt_q  <= cnt_q + 2'd1;
      end
    end
  end

  assign rec_o    = rec_q;
  assign loaded_o = loaded_q;
endmodule

// File: rtl/bit_flip.sv
module bit_flip #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned VALID_BITS = 6,
  parameter int unsigned IDX_W      = 3
) (
  input  logic [BYTE_W-1:0] d_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] d_o,
  output logic              idx_ok_o
);
  assign idx_ok_o = (32'(idx_i) < VALID_BITS);

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    if (b < VALID_BITS) begin : g_flip
      assign d_o[b] = d_i[b] ^ (idx_i == IDX_W'(b));
    end else begin : g_keep
      assign d_o[b] = d_i[b];
    end
  end
endmodule

// File: rtl/rec_emitter.sv
module rec_emitter
  import seu_inj_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned REC_W = REC_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [REC_W-1:0]  rec_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic             active_q;
  logic [1:0]       pos_q;
  logic [REC_W-1:0] rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      rec_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      pos_q    <= '0;
      rec_q    <= rec_i;
    end else if (active_q && ready_i) begin
      if (pos_q == FLD_DATA) active_q <= 1'b0;
      pos_q <= pos_q + 2'd1;
    end
  end

  assign valid_o = active_q;
  assign byte_o  = rec_q[(REC_BYTES - 1 - int'(pos_q)) * BYTE_W +: BYTE_W];

  a_r4_hold_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(byte_o)));

  a_r5_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !active_q);
endmodule

// File: rtl/seu_bit_injector.sv
module seu_bit_injector
  import seu_inj_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned VALID_BITS = 6,
  parameter int unsigned IDX_W      = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BYTE_W-1:0] in_byte_i,
  input  logic              cmd_inject_i,
  input  logic              cmd_restore_i,
  input  logic [IDX_W-1:0]  cmd_bit_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              busy_o,
  output logic              err_o
);
  localparam int unsigned REC_W = REC_BYTES * BYTE_W;

  logic [REC_W-1:0]  tgt_rec, saved_q, load_rec;
  logic [BYTE_W-1:0] flip_d;
  logic              loaded, idx_ok;
  logic              armed_q, err_q;
  logic              inj_req, rst_req, inj_bad, rst_bad, inj_go, rst_go;

  rec_capture #(.BYTE_W(BYTE_W)) cap_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (in_valid_i),
    .ready_i  (in_ready_o),
    .byte_i   (in_byte_i),
    .rec_o    (tgt_rec),
    .loaded_o (loaded)
  );

  bit_flip #(.BYTE_W(BYTE_W), .VALID_BITS(VALID_BITS), .IDX_W(IDX_W)) flip_i (
    .d_i      (tgt_rec[BYTE_W-1:0]),
    .idx_i    (cmd_bit_i),
    .d_o      (flip_d),
    .idx_ok_o (idx_ok)
  );

  // busy blocks commands silently; inject outranks restore
  always_comb begin
    inj_req  = cmd_inject_i & ~busy_o;
    rst_req  = cmd_restore_i & ~busy_o & ~cmd_inject_i;
    inj_bad  = inj_req & (~loaded | armed_q | ~idx_ok);
    inj_go   = inj_req & ~inj_bad;
    rst_bad  = rst_req & ~armed_q;
    rst_go   = rst_req & armed_q;
    load_rec = inj_go ? {tgt_rec[REC_W-1:BYTE_W], flip_d} : saved_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      saved_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= inj_bad | rst_bad;
      if (inj_go) begin
        armed_q <= 1'b1;
        saved_q <= tgt_rec;
      end else if (rst_go) begin
        armed_q <= 1'b0;
      end
    end
  end

  rec_emitter #(.BYTE_W(BYTE_W)) emit_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (inj_go | rst_go),
    .rec_i   (load_rec),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .byte_o  (out_byte_o)
  );

  assign busy_o     = out_valid_o;
  assign in_ready_o = ~busy_o & ~armed_q;
  assign err_o      = err_q;

  a_r3_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_go |-> ($countones(flip_d ^ tgt_rec[BYTE_W-1:0]) == 1));

  a_r6_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !out_valid_o);

  a_r7_restore_emits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(armed_q) |-> out_valid_o);

  a_r8_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> !in_ready_o);
endmodule

// File: tb/seu_bit_injector_tb_top.sv
`timescale 1ns/1ps
module seu_bit_injector_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] in_byte_i = '0;
  logic       cmd_inject_i = 1'b0;
  logic       cmd_restore_i = 1'b0;
  logic [2:0] cmd_bit_i = '0;
  logic       out_valid_o;
  logic       out_ready_i = 1'b0;
  logic [7:0] out_byte_o;
  logic       busy_o;
  logic       err_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  seu_bit_injector dut_i (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_byte_i,
    .cmd_inject_i, .cmd_restore_i, .cmd_bit_i,
    .out_valid_o, .out_ready_i, .out_byte_o, .busy_o, .err_o
  );

  typedef struct packed {
    logic [31:0] rec;
    logic [2:0]  idx;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h01_10_20_00, 3'd0},
    '{32'h02_7f_80_ff, 3'd5},
    '{32'h03_00_01_3c, 3'd6},
    '{32'h04_aa_55_c3, 3'd7},
    '{32'h05_12_34_a5, 3'd3},
    '{32'h06_fe_01_5a, 3'd2}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic send_byte(input logic [7:0] b);
    in_valid_i = 1'b1;
    in_byte_i  = b;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic send_rec(input logic [31:0] r);
    for (int k = 3; k >= 0; k--) send_byte(r[k*8 +: 8]);
  endtask

  task automatic cmd(input bit inj, input bit rs, input logic [2:0] b);
    cmd_inject_i  = inj;
    cmd_restore_i = rs;
    cmd_bit_i     = b;
    @(negedge clk_i);
    cmd_inject_i  = 1'b0;
    cmd_restore_i = 1'b0;
  endtask

  task automatic collect(input bit stall, input bit poke_last, output logic [31:0] got);
    logic [7:0] b0;
    got = '0;
    for (int k = 0; k < 4; k++) begin
      if (stall) begin
        out_ready_i = 1'b0;
        b0 = out_byte_o;
        @(negedge clk_i);
        chk(out_valid_o && out_byte_o == b0, "R4 hold", {23'd0, out_valid_o, out_byte_o}, {24'd1, b0});
      end
      out_ready_i = 1'b1;
      if (k == 3 && poke_last) begin
        cmd_bit_i    = 3'd0;
        cmd_inject_i = 1'b1;
      end
      chk(out_valid_o, "R3 valid", {31'd0, out_valid_o}, 32'd1);
      got = {got[23:0], out_byte_o};
      @(negedge clk_i);
      cmd_inject_i = 1'b0;
    end
    out_ready_i = 1'b0;
    chk(!out_valid_o && !busy_o, "R5 idle after record", {30'd0, out_valid_o, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] got, exp;
    repeat (3) @(negedge clk_i);
    chk(!out_valid_o && !busy_o && !err_o && in_ready_o, "R1 in reset",
        {28'd0, out_valid_o, busy_o, err_o, in_ready_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!out_valid_o && !busy_o && !err_o && in_ready_o, "R1 after reset",
        {28'd0, out_valid_o, busy_o, err_o, in_ready_o}, 32'd1);

    // R9: nothing captured yet
    cmd(1'b1, 1'b0, 3'd0);
    chk(err_o && !out_valid_o, "R9 no record", {30'd0, err_o, out_valid_o}, 32'd2);
    @(negedge clk_i);
    chk(!err_o, "R9 err one cycle", {31'd0, err_o}, 32'd0);

    // R7: restore with nothing pending
    cmd(1'b0, 1'b1, 3'd0);
    chk(err_o && !out_valid_o, "R7 restore unarmed", {30'd0, err_o, out_valid_o}, 32'd2);
    @(negedge clk_i);

    foreach (VECS[i]) begin
      send_rec(VECS[i].rec);
      cmd(1'b1, 1'b0, VECS[i].idx);
      if (VECS[i].idx >= 3'd6) begin
        chk(err_o && !out_valid_o, "R6 bad index", {30'd0, err_o, out_valid_o}, 32'd2);
        @(negedge clk_i);
        chk(!out_valid_o && in_ready_o, "R6 nothing pending", {30'd0, out_valid_o, in_ready_o}, 32'd1);
      end else begin
        chk(!err_o && busy_o, "R5 busy on inject", {30'd0, err_o, busy_o}, 32'd1);
        exp = VECS[i].rec ^ (32'd1 << VECS[i].idx);
        collect(i[0], 1'b0, got);
        chk(got == exp, "R3 flipped record", got, exp);
        chk(!in_ready_o, "R8 capture locked", {31'd0, in_ready_o}, 32'd0);
        cmd(1'b0, 1'b1, 3'd0);
        collect(~i[0], 1'b0, got);
        chk(got == VECS[i].rec, "R7 restored record", got, VECS[i].rec);
        chk(in_ready_o, "R2 ready after restore", {31'd0, in_ready_o}, 32'd1);
      end
    end

    // R8: second inject while pending
    send_rec(32'hc0_de_ad_01);
    cmd(1'b1, 1'b0, 3'd1);
    collect(1'b0, 1'b0, got);
    chk(got == 32'hc0_de_ad_03, "R3 idx1", got, 32'hc0_de_ad_03);
    cmd(1'b1, 1'b0, 3'd2);
    chk(err_o && !out_valid_o, "R8 double inject", {30'd0, err_o, out_valid_o}, 32'd2);
    @(negedge clk_i);

    // R5: restore, poke commands while busy and on the final handshake
    cmd(1'b0, 1'b1, 3'd0);
    cmd(1'b1, 1'b0, 3'd0);
    chk(!err_o && busy_o, "R5 ignored while busy", {30'd0, err_o, busy_o}, 32'd1);
    collect(1'b0, 1'b1, got);
    chk(got == 32'hc0_de_ad_01, "R7 restore after busy pokes", got, 32'hc0_de_ad_01);
    chk(!err_o, "R5 last-handshake cmd no err", {31'd0, err_o}, 32'd0);
    repeat (3) begin
      @(negedge clk_i);
      chk(!out_valid_o && !err_o, "R5 last-handshake cmd ignored", {30'd0, out_valid_o, err_o}, 32'd0);
    end

    // R10: inject and restore together
    cmd(1'b1, 1'b1, 3'd4);
    chk(!err_o && out_valid_o, "R10 inject wins", {30'd0, err_o, out_valid_o}, 32'd1);
    collect(1'b1, 1'b0, got);
    chk(got == 32'hc0_de_ad_11, "R10 flipped", got, 32'hc0_de_ad_11);
    cmd(1'b0, 1'b1, 3'd0);
    collect(1'b0, 1'b0, got);
    chk(got == 32'hc0_de_ad_01, "R10 then restore", got, 32'hc0_de_ad_01);

    // R2: new record replaces the target
    send_rec(32'h77_66_55_44);
    cmd(1'b1, 1'b0, 3'd5);
    collect(1'b0, 1'b0, got);
    chk(got == 32'h77_66_55_64, "R2 new target", got, 32'h77_66_55_64);
    cmd(1'b0, 1'b1, 3'd0);
    collect(1'b0, 1'b0, got);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule